// File: doc/BRIEF.md
# Full-Word Direct Parallel I/O Port

This block moves a single 32-bit word between the processor and an external device over two plain parallel buses. The processor issues a command with an opcode, an 8-bit immediate and, for a write, a data word. A write places the word on a set of static output lines that keep their value until the next write. A read takes a snapshot of the device's input lines and hands the word back. Both kinds of command also fire timing pulses to the device: each set bit of the immediate pulses its own strobe line for one clock.

On a write the output lines settle one full cycle before any strobe is raised, so the device always latches stable data. On a read the input lines are sampled on the same edge that raises the strobes. A one-cycle done pulse closes every accepted command. The block handles one command at a time. A command that arrives while another is still in progress is dropped, and so is a command whose opcode is not one of the two transfer codes.

Top module: `dword_port`

## Requirements
- R1: After reset, `dev_dout`, `dev_strobe`, `rsp_rdata` and `rsp_done` are all zero.
- R2: An accepted write (opcode 8'hB4) drives `cmd_wdata` onto `dev_dout` from the clock edge that accepts it. `dev_dout` then holds that value through any number of reads and ignored commands until the next accepted write.
- R3: For an accepted write, `dev_strobe` is zero in the cycle after the accepting edge. It equals the immediate in the cycle after that, and `rsp_done` is high for one cycle in the cycle after that.
- R4: An accepted read (opcode 8'hB5) loads `dev_din`, as sampled at the accepting edge, into `rsp_rdata`. In the cycle after that edge `dev_strobe` equals the immediate. `rsp_done` is high for one cycle in the cycle after that. `rsp_rdata` keeps its value until the next accepted read.
- R5: Bit i of `dev_strobe` pulses only if bit i of the immediate is 1. Each pulse lasts exactly one clock. A zero immediate completes the transfer, including the done pulse, with no strobe.
- R6: When `cmd_valid` is high with any opcode other than 8'hB4 or 8'hB5, no output changes and no done pulse follows.
- R7: A command is accepted only when the port is idle. A write occupies the two edges after its accepting edge and a read occupies the one edge after its accepting edge. A valid command presented at an occupied edge is ignored, so the earliest next acceptance is three edges after a write and two edges after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_opcode | input | 8 | 8'hB4 write, 8'hB5 read, other values ignored |
| cmd_imm | input | 8 | Strobe select, one bit per strobe line |
| cmd_wdata | input | 32 | Word to place on the output lines |
| rsp_rdata | output | 32 | Word captured by the last read |
| rsp_done | output | 1 | One-cycle completion pulse |
| dev_dout | output | 32 | Static output lines to the device |
| dev_din | input | 32 | Input lines from the device |
| dev_strobe | output | 8 | Timing pulses to the device |

## Verification
The bench targets the write ordering. A design that raised the strobe on the same edge as the new data would let the device latch a half-settled word, and the reference model catches this as a strobe one cycle early. Back-to-back valid commands exercise the busy window: a port that accepted early would lose a strobe or overwrite the output lines mid-transfer, and one that accepted late would stall a legal command. Unknown opcodes and zero immediates check that nothing moves on a rejected command and that a strobe-free transfer still ends with done. Reads with input lines that change every cycle expose a capture taken on the wrong edge.

// File: rtl/dword_port.sv
module dword_port #(
  parameter int WORD_W   = 32,
  parameter int STB_W    = 8,
  parameter int OP_W     = 8,
  parameter logic [OP_W-1:0] OP_WRITE = 8'hB4,
  parameter logic [OP_W-1:0] OP_READ  = 8'hB5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_opcode,
  input  logic [STB_W-1:0]  cmd_imm,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [WORD_W-1:0] dev_dout,
  input  logic [WORD_W-1:0] dev_din,
  output logic [STB_W-1:0]  dev_strobe
);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_FIRE} phase_t;

  phase_t           phase;
  logic [STB_W-1:0] imm_q;
  logic             acc_wr, acc_rd;

  assign acc_wr = cmd_valid && (phase == PH_IDLE) && (cmd_opcode == OP_WRITE);
  assign acc_rd = cmd_valid && (phase == PH_IDLE) && (cmd_opcode == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      imm_q      <= '0;
      dev_dout   <= '0;
      rsp_rdata  <= '0;
      dev_strobe <= '0;
      rsp_done   <= 1'b0;
    end else begin
      dev_strobe <= '0;
      rsp_done   <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (acc_wr) begin
            dev_dout <= cmd_wdata;
            imm_q    <= cmd_imm;
            phase    <= PH_SETUP;
          end else if (acc_rd) begin
            rsp_rdata  <= dev_din;
            dev_strobe <= cmd_imm;
            phase      <= PH_FIRE;
          end
        end
        PH_SETUP: begin
          dev_strobe <= imm_q;
          phase      <= PH_FIRE;
        end
        PH_FIRE: begin
          rsp_done <= 1'b1;
          phase    <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (dev_strobe == '0 && !rsp_done) || !rst_n);

  assert_out_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(dev_dout));

  assert_write_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> (dev_dout == $past(cmd_wdata) && dev_strobe == '0 && !rsp_done)
               ##1 (dev_strobe == $past(cmd_imm, 2) && !rsp_done) ##1 rsp_done);

  assert_read_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> (rsp_rdata == $past(dev_din) && dev_strobe == $past(cmd_imm) && !rsp_done)
               ##1 (rsp_done && dev_strobe == '0));

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_strobe != '0) |=> (dev_strobe == '0));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_reject_opcode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !acc_wr && !acc_rd) |=>
      ($stable(rsp_rdata) && dev_strobe == '0 && !rsp_done));

endmodule

// File: tb/dword_port_bench.sv
`timescale 1ns/1ps
module dword_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_opcode = '0;
  logic [7:0]  cmd_imm = '0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] dev_din = '0;
  logic [31:0] rsp_rdata, dev_dout;
  logic        rsp_done;
  logic [7:0]  dev_strobe;

  always #2 clk = ~clk;

  dword_port u_dword_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_imm(cmd_imm), .cmd_wdata(cmd_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .dev_dout(dev_dout), .dev_din(dev_din),
    .dev_strobe(dev_strobe)
  );

  // behavioural reference: pending events held as integers, not as a phase machine
  logic [31:0] m_out = '0, m_rd = '0;
  logic [7:0]  m_stb = '0, next_stb = '0;
  logic        m_done = 1'b0, next_done = 1'b0, later_done = 1'b0;
  int          busy = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_rd = '0; m_stb = '0; next_stb = '0;
      m_done = 0; next_done = 0; later_done = 0; busy = 0;
    end else begin
      m_stb = next_stb; next_stb = '0;
      m_done = next_done; next_done = later_done; later_done = 0;
      if (busy > 0) busy--;
      else if (cmd_valid && cmd_opcode == 8'hB4) begin
        m_out = cmd_wdata; next_stb = cmd_imm; next_done = 0; later_done = 1; busy = 2;
      end else if (cmd_valid && cmd_opcode == 8'hB5) begin
        m_rd = dev_din; m_stb = cmd_imm; next_done = 1; busy = 1;
      end
    end
  end

  int    vectors = 0, miscompares = 0;
  bit    finished = 0;
  string tag = "R1";

  task automatic compare();
    bit bad = 0;
    vectors++;
    if (dev_dout !== m_out) begin
      bad = 1; $display("FAIL %s/R2 dev_dout actual=%h expected=%h", tag, dev_dout, m_out);
    end
    if (dev_strobe !== m_stb) begin
      bad = 1; $display("FAIL %s/R5 dev_strobe actual=%h expected=%h", tag, dev_strobe, m_stb);
    end
    if (rsp_rdata !== m_rd) begin
      bad = 1; $display("FAIL %s/R4 rsp_rdata actual=%h expected=%h", tag, rsp_rdata, m_rd);
    end
    if (rsp_done !== m_done) begin
      bad = 1; $display("FAIL %s/R3 rsp_done actual=%b expected=%b", tag, rsp_done, m_done);
    end
    if (bad) miscompares++;
  endtask

  task automatic step(input bit v, input logic [7:0] op, input logic [7:0] imm,
                      input logic [31:0] wd, input logic [31:0] din, input string t);
    @(negedge clk);
    compare();
    tag = t;
    cmd_valid = v; cmd_opcode = op; cmd_imm = imm; cmd_wdata = wd; dev_din = din;
  endtask

  task automatic idle(input int n, input string t);
    for (int i = 0; i < n; i++) step(0, 8'h00, 8'h00, 32'h0, dev_din + 32'h1111_0001, t);
  endtask

  initial begin
    // R1: reset values
    repeat (3) step(1, 8'hB4, 8'hFF, 32'hDEAD_BEEF, 32'h1234_5678, "R1");
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R1");
    // R2/R3: write with stable data ahead of the strobe
    step(1, 8'hB4, 8'hA5, 32'hCAFE_0001, 32'h0, "R3");
    idle(4, "R3");
    // R4: read sampling changing input lines
    step(1, 8'hB5, 8'h3C, 32'h0, 32'h5555_AAAA, "R4");
    idle(4, "R4");
    // R5: zero immediate still completes
    step(1, 8'hB4, 8'h00, 32'h0BAD_F00D, 32'h0, "R5");
    idle(3, "R5");
    step(1, 8'hB5, 8'h00, 32'h0, 32'h7777_0000, "R5");
    idle(3, "R5");
    step(1, 8'hB5, 8'h80, 32'h0, 32'h0000_0001, "R5");
    idle(3, "R5");
    // R6: unknown opcodes leave everything untouched
    step(1, 8'hB2, 8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    step(1, 8'hB3, 8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    step(1, 8'h00, 8'h01, 32'h1, 32'h2, "R6");
    idle(3, "R6");
    // R7: valid held high across busy windows
    for (int i = 0; i < 12; i++)
      step(1, (i % 3 == 0) ? 8'hB5 : 8'hB4, 8'(i * 37 + 1), 32'(i * 32'h0101_0101), 32'(~i), "R7");
    idle(3, "R7");
    // R2: reads do not disturb the output lines
    step(1, 8'hB5, 8'h0F, 32'h9999_9999, 32'h4242_4242, "R2");
    idle(4, "R2");
    // mixed stream
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 9);
      op = (sel < 4) ? 8'hB4 : (sel < 8) ? 8'hB5 : 8'($urandom);
      step($urandom_range(0, 2) != 0, op, 8'($urandom), $urandom, $urandom, "R7");
    end
    idle(4, "R7");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule